// File: doc/BRIEF.md
# Enumerating Password Candidate Generator

This block produces a stream of fixed-length character strings for an exhaustive key search. Each string is treated as a number whose digits are characters drawn from a contiguous code range, 'A' to 'Z' by default. While the generator is idle it accepts a start string and a count. Once loaded, it emits one candidate per enabled clock cycle, starting with the start string itself. Each candidate comes with its sequence number within the run. The consumer can drop `enable` at any time to stall the stream without losing its place. After the requested number of candidates the block raises `done` and returns to idle.

Each character position steps like a digit. After the last valid code it returns to the first valid code and carries into the next position. The carry decisions do not sit in series with the character increment: each position keeps a registered "at last code" flag and a registered "all lower positions at last code" flag. Both are updated together with the string, so a ripple through every position never sets the cycle time.

Top module: `pwcand_gen`

## Requirements
- R1: After reset, `busy`, `done` and `candValid` are low.
- R2: A `load` while idle is accepted: `busy` rises on the next edge, or `done` if `total` is zero. The first emitted candidate equals `startStr` and has `candIdx` 0.
- R3: Each clock edge with `busy` and `enable` high produces one candidate one cycle later, with `candValid` high. `candIdx` increases by one per candidate. Each string is the previous one plus one, where character p sits in bits [8p+7:8p], position 0 changes fastest, and the codes run 0x41 ('A') to 0x5A ('Z').
- R4: An edge with `enable` low leaves `candValid` low and `candStr` and `candIdx` unchanged.
- R5: After exactly `total` candidates, `done` is high and `busy` low. No further candidate is emitted, and `done` holds until the next accepted load.
- R6: A load with `total` equal to 0 raises `done` at once and emits no candidate.
- R7: A position holding 'Z' that steps becomes 'A' and carries one into the next position.
- R8: Stepping past the string of all 'Z' silently gives the string of all 'A'.
- R9: A `load` while `busy` is high is ignored, and the running sequence continues unchanged.
- R10: The per-position carry comes from registered flags, which always agree with the current string. Carries through every position give correct strings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load request, accepted only while idle |
| startStr | input | NUM_POS*CHAR_W | First candidate of the run |
| total | input | CNT_W | Number of candidates to emit |
| enable | input | 1 | Advance the stream this cycle |
| candValid | output | 1 | A new candidate was emitted this cycle |
| candStr | output | NUM_POS*CHAR_W | Current candidate string |
| candIdx | output | CNT_W | Sequence number of the candidate |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has emitted all its candidates |

## Verification
The hardest state to reach is a carry rippling through every position at once, ending with the wrap from all 'Z' to all 'A'. It only happens after the full range has been walked. The bench therefore uses a three-position configuration and sweeps the whole space of 17576 strings plus a few more, from all 'A'. It checks every string against an arithmetic base-26 model. Shorter runs add periodic enable drops, a load issued mid-run, and zero and single-candidate counts.

// File: rtl/pwcand_pkg.sv
package pwcand_pkg;
  typedef struct packed {
    logic loadStr;
    logic stepStr;
  } genStrobe_t;
endpackage

// File: rtl/pwcand_ctrl.sv
module pwcand_ctrl
  import pwcand_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] total,
  input  logic             enable,
  output genStrobe_t       strobe,
  output logic             busy,
  output logic             done,
  output logic             candValid,
  output logic [CNT_W-1:0] candIdx
);
  logic [CNT_W-1:0] remainCnt;
  logic [CNT_W-1:0] emitCnt;
  logic             loadAcc;
  logic             stepNow;

  assign loadAcc = load && !busy;
  assign stepNow = busy && enable;
  assign strobe.loadStr = loadAcc;
  assign strobe.stepStr = stepNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      remainCnt <= '0;
      emitCnt   <= '0;
      candValid <= 1'b0;
      candIdx   <= '0;
    end else if (loadAcc) begin
      busy      <= (total != '0);
      done      <= (total == '0);
      remainCnt <= total;
      emitCnt   <= '0;
      candValid <= 1'b0;
    end else begin
      candValid <= stepNow;
      if (stepNow) begin
        candIdx   <= emitCnt;
        emitCnt   <= emitCnt + 1'b1;
        remainCnt <= remainCnt - 1'b1;
        if (remainCnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !candValid);
  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (candValid && $past(candValid)) |-> candIdx == $past(candIdx) + 1'b1);
  assert_pause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!candValid && $stable(candIdx)));
  assert_busy_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !enable) |=> $stable(remainCnt));
endmodule

// File: rtl/pwcand_datapath.sv
module pwcand_datapath
  import pwcand_pkg::*;
#(
  parameter int          NUM_POS    = 8,
  parameter int          CHAR_W     = 8,
  parameter logic [7:0]  CHAR_FIRST = 8'h41,
  parameter logic [7:0]  CHAR_LAST  = 8'h5A
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  genStrobe_t                  strobe,
  input  logic [NUM_POS*CHAR_W-1:0]   startStr,
  output logic [NUM_POS*CHAR_W-1:0]   candStr
);
  localparam int STR_W = NUM_POS * CHAR_W;
  localparam logic [CHAR_W-1:0] FIRST_C  = CHAR_W'(CHAR_FIRST);
  localparam logic [CHAR_W-1:0] LAST_C   = CHAR_W'(CHAR_LAST);
  localparam logic [CHAR_W-1:0] PRELAST  = CHAR_W'(CHAR_LAST) - 1'b1;
  localparam logic SINGLE_CODE = (CHAR_FIRST == CHAR_LAST);

  logic [CHAR_W-1:0]  curChar [NUM_POS];
  logic [STR_W-1:0]   curStr;
  logic [NUM_POS-1:0] lastFlag, carryIn;
  logic [NUM_POS-1:0] nextLast, nextCarry;
  logic [NUM_POS-1:0] loadLast, loadCarry;

  // Flag next-state is computed from the current flags and characters,
  // in parallel with the increment, never from the incremented result.
  always_comb begin
    for (int p = 0; p < NUM_POS; p++) begin
      if (carryIn[p])
        nextLast[p] = lastFlag[p] ? SINGLE_CODE : (curChar[p] == PRELAST);
      else
        nextLast[p] = lastFlag[p];
      loadLast[p] = (startStr[p*CHAR_W +: CHAR_W] == LAST_C);
    end
    nextCarry[0] = 1'b1;
    loadCarry[0] = 1'b1;
    for (int p = 1; p < NUM_POS; p++) begin
      nextCarry[p] = nextCarry[p-1] & nextLast[p-1];
      loadCarry[p] = loadCarry[p-1] & loadLast[p-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastFlag <= {NUM_POS{SINGLE_CODE}};
      carryIn  <= SINGLE_CODE ? {NUM_POS{1'b1}} : NUM_POS'(1);
    end else if (strobe.loadStr) begin
      lastFlag <= loadLast;
      carryIn  <= loadCarry;
    end else if (strobe.stepStr) begin
      lastFlag <= nextLast;
      carryIn  <= nextCarry;
    end
  end

  for (genvar p = 0; p < NUM_POS; p++) begin : g_pos
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        curChar[p] <= FIRST_C;
      else if (strobe.loadStr)
        curChar[p] <= startStr[p*CHAR_W +: CHAR_W];
      else if (strobe.stepStr && carryIn[p])
        curChar[p] <= lastFlag[p] ? FIRST_C : curChar[p] + 1'b1;
    end
    assign curStr[p*CHAR_W +: CHAR_W] = curChar[p];

    assert_flag_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lastFlag[p] == (curChar[p] == LAST_C));
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.stepStr && !strobe.loadStr && carryIn[p] && curChar[p] == LAST_C)
        |=> curChar[p] == FIRST_C);
    if (p > 0) begin : g_carry_chk
      assert_carry_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        carryIn[p] == (carryIn[p-1] && curChar[p-1] == LAST_C));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      candStr <= '0;
    else if (strobe.stepStr && !strobe.loadStr)
      candStr <= curStr;
  end

  assert_string_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.stepStr && !strobe.loadStr) |=> $stable(curStr) && $stable(candStr));
endmodule

// File: rtl/pwcand_gen.sv
module pwcand_gen
  import pwcand_pkg::*;
#(
  parameter int          NUM_POS    = 8,
  parameter int          CHAR_W     = 8,
  parameter logic [7:0]  CHAR_FIRST = 8'h41,
  parameter logic [7:0]  CHAR_LAST  = 8'h5A,
  parameter int          CNT_W      = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NUM_POS*CHAR_W-1:0]  startStr,
  input  logic [CNT_W-1:0]           total,
  input  logic                       enable,
  output logic                       candValid,
  output logic [NUM_POS*CHAR_W-1:0]  candStr,
  output logic [CNT_W-1:0]           candIdx,
  output logic                       busy,
  output logic                       done
);
  genStrobe_t strobe;

  pwcand_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .load(load), .total(total), .enable(enable),
    .strobe(strobe), .busy(busy), .done(done),
    .candValid(candValid), .candIdx(candIdx)
  );

  pwcand_datapath #(
    .NUM_POS(NUM_POS), .CHAR_W(CHAR_W),
    .CHAR_FIRST(CHAR_FIRST), .CHAR_LAST(CHAR_LAST)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .startStr(startStr), .candStr(candStr)
  );
endmodule

// File: tb/pwcand_gen_tb.sv
module pwcand_gen_tb_top;
  localparam int NP = 3;
  localparam int CW = 16;
  localparam int SPACE = 26 * 26 * 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [NP*8-1:0] startStr = '0;
  logic [CW-1:0] total = '0;
  logic enable = 1'b0;
  logic candValid, busy, done;
  logic [NP*8-1:0] candStr;
  logic [CW-1:0] candIdx;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pwcand_gen #(.NUM_POS(NP), .CHAR_W(8), .CHAR_FIRST(8'h41),
               .CHAR_LAST(8'h5A), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .startStr(startStr),
    .total(total), .enable(enable), .candValid(candValid),
    .candStr(candStr), .candIdx(candIdx), .busy(busy), .done(done)
  );

  function automatic logic [NP*8-1:0] strOf(int v);
    logic [NP*8-1:0] s;
    int r = v;
    for (int p = 0; p < NP; p++) begin
      s[p*8 +: 8] = 8'(8'h41 + (r % 26));
      r = r / 26;
    end
    return s;
  endfunction

  function automatic string tagOf(int k, int v);
    if (k == 0) return "R2";
    if (v == 0) return "R8";
    if (v % 676 == 0) return "R10";
    if (v % 26 == 0) return "R7";
    return "R3";
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic runBlock(int startVal, int n, int pauseEvery, int loadAt);
    int k = 0;
    int v;
    logic en;
    logic [NP*8-1:0] prevStr;
    logic [CW-1:0] prevIdx;
    logic wasBusy;
    @(negedge clk);
    load = 1'b1; startStr = strOf(startVal); total = CW'(n); enable = 1'b0;
    @(negedge clk);
    load = 1'b0;
    check(n == 0 ? "R6" : "R2", {63'd0, busy}, {63'd0, n != 0}, "busy after load");
    check(n == 0 ? "R6" : "R2", {63'd0, done}, {63'd0, n == 0}, "done after load");
    for (int cyc = 0; cyc < 2 * n + 20; cyc++) begin
      if (done) break;
      en = (pauseEvery == 0) || (cyc % pauseEvery != 0);
      prevStr = candStr; prevIdx = candIdx; wasBusy = busy;
      if (cyc == loadAt) begin
        load = 1'b1; startStr = strOf((startVal + 5000) % SPACE); total = CW'(3);
      end
      enable = en;
      @(negedge clk);
      load = 1'b0;
      if (!en && wasBusy) begin
        check("R4", {63'd0, candValid}, 64'd0, "valid while paused");
        check("R4", 64'(candStr), 64'(prevStr), "string while paused");
        check("R4", 64'(candIdx), 64'(prevIdx), "index while paused");
      end else if (candValid) begin
        v = (startVal + k) % SPACE;
        check(cyc == loadAt + 1 ? "R9" : tagOf(k, v), 64'(candStr), 64'(strOf(v)), "string");
        check(tagOf(k, v), 64'(candIdx), 64'(k), "index");
        k++;
      end
    end
    check(n == 0 ? "R6" : "R5", 64'(k), 64'(n), "candidate count");
    check("R5", {63'd0, done}, 64'd1, "done at end");
    enable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R5", {63'd0, candValid}, 64'd0, "valid after done");
      check("R5", {63'd0, done}, 64'd1, "done held");
      check("R5", {63'd0, busy}, 64'd0, "busy after done");
    end
    enable = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {63'd0, busy}, 64'd0, "busy in reset");
    check("R1", {63'd0, done}, 64'd0, "done in reset");
    check("R1", {63'd0, candValid}, 64'd0, "valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {61'd0, busy, done, candValid}, 64'd0, "flags after reset");
    runBlock(0, SPACE + 3, 0, -1);
    runBlock(25 * 26 + 24, 40, 3, -1);
    runBlock(123, 0, 0, -1);
    runBlock(100, 30, 4, 10);
    runBlock(SPACE - 2, 1, 0, -1);
    runBlock(SPACE - 2, 5, 2, -1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule